// File: doc/BRIEF.md
# Multi-Port Host Interrupt Aggregator

This block is the global control section of a storage host controller that serves several ports. Software reaches it through a 32-bit memory-mapped register interface. The block has five global registers: a read-only capabilities word, a control word, an interrupt status word with one bit per port, a read-only implemented-ports map and a read-only version word. It gathers the pending-event requests of all ports into one level-sensitive interrupt line.

A controller reset is started by software and clears itself. While the reset runs, the block holds every port's engine-start and receive-enable controls low through a halt output. When the reset finishes, all global state is back at its defaults. The block also decodes the address of each per-port register window. It does not reach into the ports themselves.

Top module: `hostglb_top`

## Requirements
- R1: After `rstN` is released, the control word (byte offset 0x04) and the status word (offset 0x08) read 0, and `irqOut` and `portHalt` are low.
- R2: The capabilities word (offset 0x00) reads the port count minus one in bits 4:0 and the command-slot count minus one in bits 12:8, with all other bits 0. The implemented-ports word (offset 0x0C) reads `IMPL_MAP` and the version word (offset 0x10) reads `VERSION`.
- R3: Status bit i becomes 1 at the first clock edge at which `portIrq[i]` is high, and it stays 1 until software writes 1 to bit i at offset 0x08. Writing 0 to a bit leaves it unchanged.
- R4: If `portIrq[i]` is high in the same cycle as a write-1-to-clear of status bit i, the bit stays 1.
- R5: `irqOut` is high exactly when the global enable (control bit 1) is 1 and at least one status bit whose `IMPL_MAP` bit is 1 is set. A status bit of an unimplemented port can be set and read, but it never raises `irqOut`.
- R6: In the control word, bit 1 (interrupt enable) and bit 31 (mode enable) can be written and read back. Bits 30:2 always read 0.
- R7: A write to offset 0x04 with bit 0 set starts a reset. From the next cycle, control bit 0 reads 1 for exactly `RESET_CYCLES` cycles and then reads 0. The reset clears the interrupt enable, the mode enable and all status bits.
- R8: While the reset runs, `portHalt` is high, status bits do not capture `portIrq`, and register writes are ignored.
- R9: An address in the range 0x100 + n*0x80 up to 0x100 + n*0x80 + 0x7F selects `portSel` bit n (one-hot), and `portOff` then gives the address bits 6:0. Any other address selects no port. Reads at port-window addresses and at unused global offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| portIrq | input | NUM_PORTS | Per-port pending enabled event, level |
| irqOut | output | 1 | Aggregated level interrupt |
| portHalt | output | 1 | Forces the ports' start and receive-enable controls low during reset |
| portSel | output | NUM_PORTS | One-hot per-port window select |
| portOff | output | 7 | Byte offset inside the selected port window |

## Verification
The bench builds the block with four ports and an implemented map of 4'b1011. Port 2 is therefore unimplemented, so the path where a status bit is set but masked from the interrupt can be exercised. `RESET_CYCLES` is set to 5. With such a short countdown, every cycle of the reset can be observed, including a write that lands in the middle of it and a port event that is held during it. With four windows, the sweep covers the lower and upper edges of the window range, both ends of one window, and the boundary between two neighbouring windows.

// File: rtl/hostglb_pkg.sv
package hostglb_pkg;

  localparam int unsigned GLB_SPAN = 'h100;
  localparam int unsigned WIN_SPAN = 'h80;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CAP,
    SEL_CTRL,
    SEL_STAT,
    SEL_IMPL,
    SEL_VER
  } rdSel_e;

  typedef struct packed {
    logic   ctrlWr;
    logic   statWr;
    logic   rstStart;
    logic   rstBusy;
    rdSel_e rdSel;
  } glbStrobe_t;

endpackage

// File: rtl/hostglb_ctrl.sv
module hostglb_ctrl
  import hostglb_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int ADDR_W       = 12,
  parameter int RESET_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 wrBit0,
  output glbStrobe_t           strb,
  output logic [NUM_PORTS-1:0] portSel,
  output logic [6:0]           portOff
);

  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [ADDR_W-1:0] GLB_LIM = ADDR_W'(GLB_SPAN);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             globalHit;
  logic [5:0]       wordIdx;
  logic [31:0]      addr32;
  rdSel_e           rdSel;

  assign globalHit = busAddr < GLB_LIM;
  assign wordIdx   = busAddr[7:2];
  assign addr32    = 32'(busAddr);

  always_comb begin
    rdSel = SEL_NONE;
    if (globalHit) begin
      case (wordIdx)
        6'd0:    rdSel = SEL_CAP;
        6'd1:    rdSel = SEL_CTRL;
        6'd2:    rdSel = SEL_STAT;
        6'd3:    rdSel = SEL_IMPL;
        6'd4:    rdSel = SEL_VER;
        default: rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb.rdSel    = rdSel;
    strb.rstBusy  = busyQ;
    strb.ctrlWr   = busWrEn && !busyQ && (rdSel == SEL_CTRL);
    strb.statWr   = busWrEn && !busyQ && (rdSel == SEL_STAT);
    strb.rstStart = busWrEn && !busyQ && (rdSel == SEL_CTRL) && wrBit0;
  end

  // reset sequencer: busy for exactly RESET_CYCLES cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (strb.rstStart) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_W'(RESET_CYCLES - 1);
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  // per-port window decode
  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_win
    localparam int unsigned WIN_LO = GLB_SPAN + n * WIN_SPAN;
    assign portSel[n] = (addr32 >= WIN_LO) && (addr32 < WIN_LO + WIN_SPAN);
  end
  assign portOff = busAddr[6:0];

  // R7
  rst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rstStart |=> strb.rstBusy);

  // R9
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portSel));

endmodule

// File: rtl/hostglb_regs.sv
module hostglb_regs
  import hostglb_pkg::*;
#(
  parameter int          NUM_PORTS = 4,
  parameter int          NUM_SLOTS = 32,
  parameter logic [31:0] IMPL_MAP  = 32'h0000_000F,
  parameter logic [31:0] VERSION   = 32'h0001_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  glbStrobe_t           strb,
  input  logic [31:0]          busWrData,
  input  logic [NUM_PORTS-1:0] portIrq,
  output logic [31:0]          busRdData,
  output logic                 irqOut,
  output logic                 portHalt
);

  localparam logic [31:0] CAP_VAL =
    {19'b0, 5'(NUM_SLOTS - 1), 3'b0, 5'(NUM_PORTS - 1)};
  localparam logic [NUM_PORTS-1:0] IMPL_V = NUM_PORTS'(IMPL_MAP);

  logic                 ienQ;
  logic                 modeQ;
  logic [NUM_PORTS-1:0] statusQ;
  logic [NUM_PORTS-1:0] clrMask;
  logic                 unusedWd;

  assign unusedWd = ^busWrData;
  assign clrMask  = strb.statWr ? busWrData[NUM_PORTS-1:0] : '0;

  // status: set from ports wins over write-1-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            statusQ <= '0;
    else if (strb.rstStart || strb.rstBusy) statusQ <= '0;
    else                                  statusQ <= (statusQ & ~clrMask) | portIrq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienQ  <= 1'b0;
      modeQ <= 1'b0;
    end else if (strb.rstStart) begin
      ienQ  <= 1'b0;
      modeQ <= 1'b0;
    end else if (strb.ctrlWr) begin
      ienQ  <= busWrData[1];
      modeQ <= busWrData[31];
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CAP:  busRdData = CAP_VAL;
      SEL_CTRL: busRdData = {modeQ, 29'b0, ienQ, strb.rstBusy};
      SEL_STAT: busRdData = 32'(statusQ);
      SEL_IMPL: busRdData = 32'(IMPL_V);
      SEL_VER:  busRdData = VERSION;
      default:  busRdData = 32'b0;
    endcase
  end

  assign irqOut   = ienQ && |(statusQ & IMPL_V);
  assign portHalt = strb.rstBusy;

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.statWr && !strb.rstStart && !strb.rstBusy)
      |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rstStart && !strb.rstBusy)
      |=> ((statusQ & $past(portIrq)) == $past(portIrq)));

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0));

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rstBusy |-> (statusQ == '0 && !ienQ && !modeQ));

endmodule

// File: rtl/hostglb_top.sv
module hostglb_top
  import hostglb_pkg::*;
#(
  parameter int          NUM_PORTS    = 4,
  parameter int          NUM_SLOTS    = 32,
  parameter int          ADDR_W       = 12,
  parameter int          RESET_CYCLES = 16,
  parameter logic [31:0] IMPL_MAP     = 32'h0000_000F,
  parameter logic [31:0] VERSION      = 32'h0001_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_PORTS-1:0] portIrq,
  output logic                 irqOut,
  output logic                 portHalt,
  output logic [NUM_PORTS-1:0] portSel,
  output logic [6:0]           portOff
);

  glbStrobe_t strb;

  hostglb_ctrl #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .RESET_CYCLES(RESET_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .wrBit0(busWrData[0]), .strb(strb), .portSel(portSel), .portOff(portOff)
  );

  hostglb_regs #(
    .NUM_PORTS(NUM_PORTS), .NUM_SLOTS(NUM_SLOTS),
    .IMPL_MAP(IMPL_MAP), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .portIrq(portIrq), .busRdData(busRdData), .irqOut(irqOut),
    .portHalt(portHalt)
  );

endmodule

// File: tb/tb_hostglb_top.sv
`timescale 1ns/1ps
module tb_hostglb_top;

  localparam int NP = 4;
  localparam int AW = 12;
  localparam int RC = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [NP-1:0] portIrq = '0;
  logic          irqOut;
  logic          portHalt;
  logic [NP-1:0] portSel;
  logic [6:0]    portOff;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hostglb_top #(
    .NUM_PORTS(NP), .NUM_SLOTS(32), .ADDR_W(AW), .RESET_CYCLES(RC),
    .IMPL_MAP(32'h0000_000B), .VERSION(32'h0001_0200)
  ) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .portIrq(portIrq),
    .irqOut(irqOut), .portHalt(portHalt), .portSel(portSel), .portOff(portOff)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [3:0]  pin;
    logic        chk;
    logic [31:0] exp;
    logic        irq;
    logic [7:0]  req;
  } vec_t;

  // outputs are checked before the clock edge that applies the row's inputs
  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 32'h0000_1F03, 1'b0, 8'd2}, // R2 cap
    '{1'b0, 12'h00C, 32'h0,         4'h0, 1'b1, 32'h0000_000B, 1'b0, 8'd2}, // R2 impl
    '{1'b0, 12'h010, 32'h0,         4'h0, 1'b1, 32'h0001_0200, 1'b0, 8'd2}, // R2 version
    '{1'b1, 12'h004, 32'h8000_0002, 4'h0, 1'b0, 32'h0,         1'b0, 8'd6}, // R6 write
    '{1'b0, 12'h004, 32'h0,         4'h0, 1'b1, 32'h8000_0002, 1'b0, 8'd6}, // R6 readback
    '{1'b0, 12'h008, 32'h0,         4'h1, 1'b1, 32'h0,         1'b0, 8'd3}, // R3 port0 event
    '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 32'h1,         1'b1, 8'd3}, // R3 captured, R5 irq
    '{1'b1, 12'h008, 32'h0,         4'h0, 1'b0, 32'h0,         1'b1, 8'd3}, // R3 write 0
    '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 32'h1,         1'b1, 8'd3}, // R3 unchanged
    '{1'b1, 12'h008, 32'h1,         4'h0, 1'b0, 32'h0,         1'b1, 8'd3}, // R3 clear
    '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 32'h0,         1'b0, 8'd3}, // R3 cleared
    '{1'b0, 12'h008, 32'h0,         4'h4, 1'b1, 32'h0,         1'b0, 8'd5}, // R5 port2 event
    '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 32'h4,         1'b0, 8'd5}, // R5 masked
    '{1'b1, 12'h008, 32'h4,         4'h0, 1'b0, 32'h0,         1'b0, 8'd5},
    '{1'b0, 12'h008, 32'h0,         4'h8, 1'b1, 32'h0,         1'b0, 8'd4}, // R4 port3 event
    '{1'b1, 12'h008, 32'h8,         4'h8, 1'b0, 32'h0,         1'b1, 8'd4}, // R4 clear vs set
    '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 32'h8,         1'b1, 8'd4}, // R4 set wins
    '{1'b1, 12'h004, 32'h8000_0000, 4'h0, 1'b0, 32'h0,         1'b1, 8'd5},
    '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 32'h8,         1'b0, 8'd5}, // R5 enable gate
    '{1'b0, 12'h004, 32'h0,         4'h0, 1'b1, 32'h8000_0000, 1'b0, 8'd6}, // R6
    '{1'b1, 12'h004, 32'h7FFF_FFFE, 4'h0, 1'b0, 32'h0,         1'b0, 8'd6},
    '{1'b0, 12'h004, 32'h0,         4'h0, 1'b1, 32'h0000_0002, 1'b1, 8'd6}, // R6 other bits 0
    '{1'b0, 12'h014, 32'h0,         4'h0, 1'b1, 32'h0,         1'b1, 8'd9}, // R9 unused offset
    '{1'b0, 12'h180, 32'h0,         4'h0, 1'b1, 32'h0,         1'b1, 8'd9}  // R9 window read
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic wr, input int a, input logic [31:0] wd,
                       input logic [NP-1:0] pin);
    @(negedge clk);
    busWrEn   = wr;
    busAddr   = AW'(a);
    busWrData = wd;
    portIrq   = pin;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    drive(1'b0, 'h004, 32'h0, '0);
    check("R1", "ctrl", busRdData, 32'h0);
    check("R1", "irqOut", 32'(irqOut), 32'h0);
    check("R1", "portHalt", 32'(portHalt), 32'h0);
    drive(1'b0, 'h008, 32'h0, '0);
    check("R1", "status", busRdData, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", TBL[i].req);
      drive(TBL[i].wr, int'(TBL[i].addr), TBL[i].wd, TBL[i].pin);
      if (TBL[i].chk) check(rq, $sformatf("row %0d read", i), busRdData, TBL[i].exp);
      check(rq, $sformatf("row %0d irq", i), 32'(irqOut), 32'(TBL[i].irq));
    end

    // R9 window decode sweep
    begin
      int wa [7] = '{'h0FC, 'h100, 'h17F, 'h180, 'h2FC, 'h300, 'h000};
      for (int k = 0; k < 7; k++) begin
        logic [NP-1:0] expSel;
        expSel = '0;
        if (wa[k] >= 'h100 && wa[k] < 'h100 + NP * 'h80)
          expSel = NP'(1) << ((wa[k] - 'h100) >> 7);
        drive(1'b0, wa[k], 32'h0, '0);
        check("R9", $sformatf("portSel @0x%0h", wa[k]), 32'(portSel), 32'(expSel));
        if (expSel != '0)
          check("R9", $sformatf("portOff @0x%0h", wa[k]), 32'(portOff), 32'(wa[k] & 'h7F));
      end
    end

    // R7 / R8 reset sequence: ien=1, status=8 at this point
    drive(1'b1, 'h004, 32'h8000_0003, 4'hF);
    for (int i = 0; i < RC; i++) begin
      if (i == 2)      drive(1'b1, 'h004, 32'h8000_0002, 4'hF);
      else if (i == 3) drive(1'b0, 'h008, 32'h0, 4'hF);
      else             drive(1'b0, 'h004, 32'h0, 4'hF);
      check(i == 3 ? "R8" : "R7", $sformatf("busy cycle %0d read", i),
            busRdData, i == 3 ? 32'h0 : 32'h1);
      check("R8", $sformatf("busy cycle %0d portHalt", i), 32'(portHalt), 32'h1);
      check("R7", $sformatf("busy cycle %0d irq", i), 32'(irqOut), 32'h0);
    end
    drive(1'b0, 'h008, 32'h0, 4'hF);
    check("R8", "status held during reset", busRdData, 32'h0);
    check("R7", "portHalt after reset", 32'(portHalt), 32'h0);
    drive(1'b0, 'h008, 32'h0, 4'h0);
    check("R7", "status captures after reset", busRdData, 32'hF);
    check("R7", "irq disabled after reset", 32'(irqOut), 32'h0);
    drive(1'b0, 'h004, 32'h0, 4'h0);
    check("R7", "ctrl defaults after reset", busRdData, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule